// File: doc/BRIEF.md
# Prescaled Match-Reload Timer Counter

This block is an 8-bit up-counter that a CPU programs through a small register bus. A free-running divider produces a timer tick from the system clock. A two-bit select picks how often the tick fires: every cycle, every 4th, every 32nd or every 256th cycle. The counter advances on each tick.

When the counter equals the compare register on a tick, it loads one instead of advancing. On the next cycle the block raises a one-cycle match pulse. The counter also loads one on reset and whenever the CPU writes its address, whatever data is written. The block therefore behaves as a period generator whose period is set by the compare value and the tick rate.

The bus has an address, a write strobe, write data and combinational read data taken from registered state. The counter is at 8'h10, the compare register at 8'h11 and the prescale control at 8'h1F.

Top module: `tick_reload_timer`

## Requirements
- R1: A synchronous active-low reset sets the counter to 8'h01, the compare register to 8'hFF, the prescale select to 00 and the match output low. It also clears the internal divider to zero.
- R2: The divider increments every clock. A tick occurs when the divider's low k bits are all ones. Select 00 gives k=0 (a tick every cycle), 01 gives k=2 (divide by 4), 10 gives k=5 (divide by 32) and 11 gives k=8 (divide by 256).
- R3: On a tick with no counter write and no compare equality, the counter increments by one. Without a tick, the counter holds its value.
- R4: On a tick where the counter equals the compare register and there is no counter write, the counter loads 8'h01.
- R5: `match_pulse` is high for exactly the cycle after an edge on which R4's reload happened, and low otherwise. In that cycle the counter reads 8'h01.
- R6: A write strobe to address 8'h10 loads the counter with 8'h01 whatever the write data. This write takes priority over a tick in the same cycle, and no match pulse follows.
- R7: The compare register at address 8'h11 takes the full write data on a write strobe and reads it back.
- R8: The control register at 8'h1F stores write-data bits [1:0] as the prescale select. Bits [7:2] always read as zero, and writes to them have no effect.
- R9: Read data is a combinational function of the address and the registered state. Any address other than 8'h10, 8'h11 and 8'h1F reads 8'h00.
- R10: When the compare value is below the current count, the counter keeps incrementing through 8'hFF to 8'h00 and reloads only on reaching the compare value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| match_pulse | output | 1 | One-cycle pulse after a compare reload |

## Verification
The hardest case to reach from the ports is a reload at the slowest rate. This needs the divider phase, the count and the compare value to line up, and a full period takes up to 65,280 cycles. The bench sweeps all four rates against small compare values (1, 3, 7, 16), so every rate reaches several reloads within a few thousand cycles. A compare value of one gives back-to-back matches. A separate phase moves the compare value below a running count to force the pass through 8'hFF and 8'h00. Back-to-back counter writes at the every-cycle rate force a write and a tick to coincide.

// File: rtl/tmr_pkg.sv
// Shared types for the prescaled match-reload timer.
// Assumes: four prescale rates, encoded as listed in ps_sel_e.
package tmr_pkg;

    typedef enum logic [1:0] {
        PS_DIV1   = 2'd0,
        PS_DIV4   = 2'd1,
        PS_DIV32  = 2'd2,
        PS_DIV256 = 2'd3
    } ps_sel_e;

    localparam int NUM_RATES = 4;

    // log2 of the divide ratio for each select code
    function automatic int rate_log2(input int idx);
        case (idx)
            0:       return 0;
            1:       return 2;
            2:       return 5;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
// Free-running divider and tap selection that produce the timer tick.
// Assumes: DIV_W is at least the largest rate_log2 value; the tick is
// a same-clock enable, never a derived clock.
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic    clk,
    input  logic    rst_n,
    input  ps_sel_e sel,
    output logic    tick
);

    logic [DIV_W-1:0]     div_q;
    logic [NUM_RATES-1:0] tap_hit;

    // Divider: clears on reset, otherwise counts every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    // One tap per rate: high when the low LOG bits of the divider are all ones
    for (genvar g = 0; g < NUM_RATES; g++) begin : g_tap
        localparam int LOG = rate_log2(g);
        if (LOG == 0) begin : g_every
            assign tap_hit[g] = 1'b1;
        end else if (LOG <= DIV_W) begin : g_low
            assign tap_hit[g] = &div_q[LOG-1:0];
        end else begin : g_full
            assign tap_hit[g] = &div_q;
        end
    end

    assign tick = tap_hit[sel];

    // R2
    div_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> div_q == $past(div_q) + 1'b1);

endmodule

// File: rtl/tmr_counter.sv
// Match-reload up-counter with a registered match pulse.
// Assumes: load_one is a single-cycle CPU write strobe and tick is a
// clock enable from the prescaler.
module tmr_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_one,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             match_q
);

    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(1);

    logic equal;
    logic hit;

    assign equal = (cnt_q == cmp_val);
    assign hit   = tick & equal & ~load_one;

    // Count register: a write beats a tick, equality on a tick reloads
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= RELOAD;
        else if (load_one) cnt_q <= RELOAD;
        else if (tick)     cnt_q <= equal ? RELOAD : cnt_q + 1'b1;
    end

    // Match pulse: registered copy of a tick-time compare hit
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= hit;
    end

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_one) |=> $stable(cnt_q));
    // R3
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_one && cnt_q != cmp_val) |=> cnt_q == $past(cnt_q) + 1'b1);
    // R4
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_one && cnt_q == cmp_val) |=> cnt_q == RELOAD);
    // R5
    pulse_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_q |-> cnt_q == RELOAD);
    // R6
    write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_one |=> (cnt_q == RELOAD && !match_q));
    // R10
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_one && cnt_q == '1 && cmp_val != '1) |=> cnt_q == '0);

endmodule

// File: rtl/tmr_regs.sv
// Bus decode, compare and prescale-control registers, and read mux.
// Assumes: DATA_W >= 2; one access per cycle; reads have no side effects.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] CNT_ADDR = 8'h10,
    parameter logic [ADDR_W-1:0] CMP_ADDR = 8'h11,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h1F,
    parameter logic [DATA_W-1:0] CMP_RST  = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cnt_val,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] cmp_q,
    output ps_sel_e           sel_q,
    output logic              cnt_wr
);

    logic cmp_wr;
    logic ctl_wr;

    assign cnt_wr = we & (addr == CNT_ADDR);
    assign cmp_wr = we & (addr == CMP_ADDR);
    assign ctl_wr = we & (addr == CTL_ADDR);

    // Compare register: full-width write
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= CMP_RST;
        else if (cmp_wr) cmp_q <= wdata;
    end

    // Prescale select: only the two low write bits are kept
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= PS_DIV1;
        else if (ctl_wr) sel_q <= ps_sel_e'(wdata[1:0]);
    end

    // Read mux over registered state; unmapped addresses return zero
    always_comb begin
        rdata = '0;
        if (addr == CNT_ADDR)      rdata = cnt_val;
        else if (addr == CMP_ADDR) rdata = cmp_q;
        else if (addr == CTL_ADDR) rdata[1:0] = sel_q;
    end

    // R7
    cmp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr |=> cmp_q == $past(wdata));
    // R8
    ctl_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == CTL_ADDR) |-> rdata[DATA_W-1:2] == '0);
    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != CNT_ADDR && addr != CMP_ADDR && addr != CTL_ADDR) |-> rdata == '0);

endmodule

// File: rtl/tick_reload_timer.sv
// Top level: prescaled 8-bit timer that reloads to one on compare match.
// Assumes: synchronous active-low reset; a single-cycle bus write strobe.
module tick_reload_timer
    import tmr_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                CNT_W    = 8,
    parameter int                DIV_W    = 8,
    parameter logic [ADDR_W-1:0] CNT_ADDR = 8'h10,
    parameter logic [ADDR_W-1:0] CMP_ADDR = 8'h11,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h1F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              match_pulse
);

    logic             tick;
    logic             cnt_wr;
    ps_sel_e          sel;
    logic [CNT_W-1:0] cmp_val;
    logic [CNT_W-1:0] cnt_val;

    tmr_regs #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (CNT_W),
        .CNT_ADDR(CNT_ADDR),
        .CMP_ADDR(CMP_ADDR),
        .CTL_ADDR(CTL_ADDR),
        .CMP_RST ({CNT_W{1'b1}})
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .we     (bus_we),
        .wdata  (bus_wdata),
        .cnt_val(cnt_val),
        .rdata  (bus_rdata),
        .cmp_q  (cmp_val),
        .sel_q  (sel),
        .cnt_wr (cnt_wr)
    );

    tmr_prescaler #(
        .DIV_W(DIV_W)
    ) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .sel  (sel),
        .tick (tick)
    );

    tmr_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .load_one(cnt_wr),
        .cmp_val (cmp_val),
        .cnt_q   (cnt_val),
        .match_q (match_pulse)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (cnt_val == CNT_W'(1) && !match_pulse && sel == PS_DIV1));

endmodule

// File: tb/tick_reload_timer_test.sv
`timescale 1ns/1ps
module tick_reload_timer_test;

    localparam logic [7:0] A_CNT = 8'h10;
    localparam logic [7:0] A_CMP = 8'h11;
    localparam logic [7:0] A_CTL = 8'h1F;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] addr;
    logic       we;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       match;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    tick_reload_timer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (addr),
        .bus_we     (we),
        .bus_wdata  (wdata),
        .bus_rdata  (rdata),
        .match_pulse(match)
    );

    // Reference state computed from the requirements
    logic [7:0] m_div, m_cnt, m_cmp;
    logic [1:0] m_sel;
    logic       m_match;
    logic       m_tick;
    logic       m_cwr;

    // R2: tick when the low k divider bits are all ones
    assign m_tick = (m_sel == 2'd0) ||
                    (m_sel == 2'd1 && m_div[1:0] == 2'b11) ||
                    (m_sel == 2'd2 && m_div[4:0] == 5'h1F) ||
                    (m_sel == 2'd3 && m_div == 8'hFF);
    assign m_cwr = we && addr == A_CNT;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_div <= 8'h00; m_cnt <= 8'h01; m_cmp <= 8'hFF;
            m_sel <= 2'd0;  m_match <= 1'b0;
        end else begin
            m_div <= m_div + 8'h01;
            if (m_cwr)       m_cnt <= 8'h01;
            else if (m_tick) m_cnt <= (m_cnt == m_cmp) ? 8'h01 : m_cnt + 8'h01;
            m_match <= m_tick && !m_cwr && (m_cnt == m_cmp);
            if (we && addr == A_CMP) m_cmp <= wdata;
            if (we && addr == A_CTL) m_sel <= wdata[1:0];
        end
    end

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        case (a)
            A_CNT:   return m_cnt;
            A_CMP:   return m_cmp;
            A_CTL:   return {6'b0, m_sel};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        #1;
        chk(tag, "rdata", rdata, exp_rd(addr));
        chk(tag, "match", {7'b0, match}, {7'b0, m_match});
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
        addr = a; we = 1'b1; wdata = d;
        cyc(tag);
        we = 1'b0; addr = A_CNT;
    endtask

    task automatic read_all(input string tag);
        addr = A_CNT; cyc(tag);
        addr = A_CMP; cyc(tag);
        addr = A_CTL; cyc(tag);
        addr = A_CNT;
    endtask

    initial begin
        int cmps[4] = '{1, 3, 7, 16};
        int logs[4] = '{0, 2, 5, 8};
        rst_n = 1'b0; we = 1'b0; addr = A_CNT; wdata = 8'h00;
        run(3, "R1");
        rst_n = 1'b1;
        // R1: reset values observed at each address
        read_all("R1");
        // R3 and R4: default compare FF at full rate, through a reload
        run(300, "R3/R4");
        // R9: unmapped addresses read zero
        addr = 8'h00; cyc("R9");
        addr = 8'h12; cyc("R9");
        addr = 8'h1E; cyc("R9");
        addr = 8'hFF; cyc("R9");
        // R7: compare read-back
        wr(A_CMP, 8'h5A, "R7");
        addr = A_CMP; cyc("R7");
        // R8: upper control bits dropped
        wr(A_CTL, 8'hFE, "R8");
        addr = A_CTL; cyc("R8");
        addr = A_CNT;
        // R2, R4, R5: sweep all rates against small compare values
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 4; c++) begin
                wr(A_CTL, 8'(s), "R2");
                wr(A_CMP, 8'(cmps[c]), "R4");
                wr(A_CNT, 8'hC3, "R6");
                run((cmps[c] + 3) * (1 << logs[s]), "R2/R4/R5");
            end
        end
        // R6: back-to-back counter writes, each colliding with a tick
        wr(A_CTL, 8'h00, "R6");
        wr(A_CMP, 8'h01, "R6");
        for (int i = 0; i < 6; i++) wr(A_CNT, 8'(i * 37 + 5), "R6");
        run(4, "R6");
        // R10: compare moved below a running count forces a wrap
        wr(A_CMP, 8'hFF, "R10");
        wr(A_CNT, 8'h00, "R10");
        run(64, "R10");
        wr(A_CMP, 8'h08, "R10");
        run(270, "R10");
        // R1: reset while running
        wr(A_CTL, 8'h03, "R1");
        run(10, "R1");
        rst_n = 1'b0;
        cyc("R1");
        rst_n = 1'b1;
        read_all("R1");
        run(20, "R1/R2");
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule